// File: doc/BRIEF.md
# Fixed Off-Time Chopper Bridge Controller

This block is a clocked controller for a single full H-bridge. It takes a direction input and an active-high bridge-off input and produces four switch commands: a high-side (source) and a low-side (sink) switch on each of the two bridge legs, A and B. Driving side A high means source A and sink B conduct. Driving side A low means source B and sink A conduct.

Peak current is regulated by a digital over-current trip from an external comparator. When the trip is accepted, only the conducting source switch opens. Its diagonal sink stays closed, so the load current recirculates and decays slowly. After a programmable off-time the source closes again. A blanking window then masks the trip, which sets a minimum on-time. The same blanking window is restarted after every direction change and after every re-enable. A direction change first passes through a dead time with all four switches open. A single fault bit, which collects thermal and undervoltage shutdown, opens every switch for as long as it is high.

The off-time, blanking and dead-time lengths are static configuration inputs counted in clock cycles. All three must be nonzero, and the blanking length must be shorter than the off-time.

Top module: `chopBridgeCtl`

## Requirements
- R1: When the bridge-off input `bridgeOffIn` is 1, all four switch outputs are 0 from the third rising clock edge after it is sampled, whatever the direction. The input path has a two-flop synchronizer followed by the state register.
- R2: With the bridge enabled and the bridge conducting, `dirIn`=1 turns on `srcA` and `snkB`, and `dirIn`=0 turns on `srcB` and `snkA`. The other two outputs stay 0.
- R3: An accepted trip (`tripIn`=1 while a source is on and blanking has expired) clears the active source on the next edge. The diagonal sink stays 1.
- R4: After a trip, the source stays off for exactly `offTime` cycles and then turns back on.
- R5: Each time an off-time ends, `tripIn` is ignored for `blankTime` cycles. The earliest accepted trip is in the following cycle.
- R6: A change of the synchronized direction while the bridge conducts opens all four switches for exactly `deadTime` cycles. The bridge then conducts in the new direction, and a fresh blanking window starts. A sink on one side is never followed directly by a sink on the other side.
- R7: When the bridge is re-enabled after being off, it conducts in the next cycle and starts a full blanking window before any trip is accepted.
- R8: `faultIn`=1 opens all four switches on the next edge and keeps them open while it stays 1. After it clears, operation resumes as in R7.
- R9: The source and sink on the same side are never 1 in the same cycle.
- R10: During and right after reset all outputs are 0. Operation then starts as on a re-enable, with a full blanking window.
- R11: `tripIn` has no effect while no source is on, that is, during an off-time, a dead time, or while the bridge is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dirIn | input | 1 | Direction request (1: side A high) |
| bridgeOffIn | input | 1 | 1 opens all switches |
| tripIn | input | 1 | Over-current comparator output |
| faultIn | input | 1 | Thermal or undervoltage shutdown |
| offTime | input | CW | Off-time in cycles |
| blankTime | input | CW | Blanking length in cycles |
| deadTime | input | CW | Crossover dead time in cycles |
| srcA | output | 1 | Source switch, side A |
| srcB | output | 1 | Source switch, side B |
| snkA | output | 1 | Sink switch, side A |
| snkB | output | 1 | Sink switch, side B |

## Verification
The bench holds the trip high straight out of reset and out of every off-time. An off-by-one in the blanking or off-time counters then moves the chop edge by a cycle, and the cycle-accurate model catches it. Direction flips are made during both conduction and chopping. A design that skipped the dead time, kept the old direction, or forgot to restart blanking would show a switch pattern the model does not expect. The bench also drives trips during dead time, off-time and bridge-off, and applies faults in the middle of a chop. These catch a design that latches a stale trip, or that resumes without a full blanking window.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEAD = 2'd1,
    ST_ON   = 2'd2,
    ST_CHOP = 2'd3
  } chopState_t;

  typedef struct packed {
    logic loadDead;
    logic loadOff;
    logic loadBlank;
  } chopStrobe_t;
endpackage

// File: rtl/chopTimerPath.sv
module chopTimerPath
  import chop_pkg::*;
#(
  parameter int CW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dirIn,
  input  logic          bridgeOffIn,
  input  logic [CW-1:0] offTime,
  input  logic [CW-1:0] blankTime,
  input  logic [CW-1:0] deadTime,
  input  chopStrobe_t   strobe,
  output logic          dirSync,
  output logic          offSync,
  output logic          cntDone,
  output logic          blankBusy
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [SYNC_STAGES-1:0] dirPipe;
  logic [SYNC_STAGES-1:0] offPipe;
  logic [CW-1:0] phaseCnt;
  logic [CW-1:0] blankCnt;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            dirPipe[g] <= 1'b0;
            offPipe[g] <= 1'b1;
          end else begin
            dirPipe[g] <= dirIn;
            offPipe[g] <= bridgeOffIn;
          end
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            dirPipe[g] <= 1'b0;
            offPipe[g] <= 1'b1;
          end else begin
            dirPipe[g] <= dirPipe[g-1];
            offPipe[g] <= offPipe[g-1];
          end
        end
      end
    end
  endgenerate

  assign dirSync = dirPipe[SYNC_STAGES-1];
  assign offSync = offPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (strobe.loadDead) begin
      phaseCnt <= deadTime;
    end else if (strobe.loadOff) begin
      phaseCnt <= offTime;
    end else if (phaseCnt != '0) begin
      phaseCnt <= phaseCnt - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blankCnt <= '0;
    end else if (strobe.loadBlank) begin
      blankCnt <= blankTime;
    end else if (blankCnt != '0) begin
      blankCnt <= blankCnt - ONE;
    end
  end

  assign cntDone   = (phaseCnt == ONE);
  assign blankBusy = (blankCnt != '0);
endmodule

// File: rtl/chopCtl.sv
module chopCtl
  import chop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dirSync,
  input  logic        offSync,
  input  logic        faultIn,
  input  logic        tripIn,
  input  logic        cntDone,
  input  logic        blankBusy,
  output chopStrobe_t strobe,
  output logic        srcA,
  output logic        srcB,
  output logic        snkA,
  output logic        snkB
);
  chopState_t state, stateNext;
  logic curDir, curDirNext;

  always_comb begin
    stateNext  = state;
    curDirNext = curDir;
    strobe     = '0;
    if (faultIn || offSync) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          stateNext        = ST_ON;
          curDirNext       = dirSync;
          strobe.loadBlank = 1'b1;
        end
        ST_DEAD: begin
          if (cntDone) begin
            stateNext        = ST_ON;
            curDirNext       = dirSync;
            strobe.loadBlank = 1'b1;
          end
        end
        ST_ON: begin
          if (dirSync != curDir) begin
            stateNext       = ST_DEAD;
            strobe.loadDead = 1'b1;
          end else if (!blankBusy && tripIn) begin
            stateNext      = ST_CHOP;
            strobe.loadOff = 1'b1;
          end
        end
        ST_CHOP: begin
          if (dirSync != curDir) begin
            stateNext       = ST_DEAD;
            strobe.loadDead = 1'b1;
          end else if (cntDone) begin
            stateNext        = ST_ON;
            strobe.loadBlank = 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      curDir <= 1'b0;
    end else begin
      state  <= stateNext;
      curDir <= curDirNext;
    end
  end

  logic conducting;
  assign conducting = (state == ST_ON) || (state == ST_CHOP);
  assign srcA = (state == ST_ON) && curDir;
  assign srcB = (state == ST_ON) && !curDir;
  assign snkB = conducting && curDir;
  assign snkA = conducting && !curDir;
endmodule

// File: rtl/chopBridgeCtl.sv
module chopBridgeCtl
  import chop_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dirIn,
  input  logic          bridgeOffIn,
  input  logic          tripIn,
  input  logic          faultIn,
  input  logic [CW-1:0] offTime,
  input  logic [CW-1:0] blankTime,
  input  logic [CW-1:0] deadTime,
  output logic          srcA,
  output logic          srcB,
  output logic          snkA,
  output logic          snkB
);
  chopStrobe_t strobe;
  logic dirSync, offSync, cntDone, blankBusy;

  chopTimerPath #(.CW(CW), .SYNC_STAGES(2)) u_path (
    .clk(clk), .rstN(rstN), .dirIn(dirIn), .bridgeOffIn(bridgeOffIn),
    .offTime(offTime), .blankTime(blankTime), .deadTime(deadTime),
    .strobe(strobe), .dirSync(dirSync), .offSync(offSync),
    .cntDone(cntDone), .blankBusy(blankBusy)
  );

  chopCtl u_ctl (
    .clk(clk), .rstN(rstN), .dirSync(dirSync), .offSync(offSync),
    .faultIn(faultIn), .tripIn(tripIn), .cntDone(cntDone),
    .blankBusy(blankBusy), .strobe(strobe),
    .srcA(srcA), .srcB(srcB), .snkA(snkA), .snkB(snkB)
  );
endmodule

// File: rtl/chopBridgeCtl_chk.sv
module chopBridgeCtl_chk (
  input logic clk,
  input logic rstN,
  input logic bridgeOffIn,
  input logic tripIn,
  input logic faultIn,
  input logic srcA,
  input logic srcB,
  input logic snkA,
  input logic snkB
);
  AST_NO_SHOOT_A: assert property (@(posedge clk) disable iff (!rstN)
    !(srcA && snkA)); // R9
  AST_NO_SHOOT_B: assert property (@(posedge clk) disable iff (!rstN)
    !(srcB && snkB)); // R9
  AST_DIAG_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (srcA |-> (snkB && !srcB)) and (srcB |-> (snkA && !srcA))); // R2
  AST_CHOP_NEEDS_TRIP: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(srcA) && snkB) |-> $past(tripIn)); // R3
  AST_FAULT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    $past(faultIn) |-> !(srcA || srcB || snkA || snkB)); // R8
  AST_OFF_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(bridgeOffIn, 1) && $past(bridgeOffIn, 2) && $past(bridgeOffIn, 3))
      |-> !(srcA || srcB || snkA || snkB)); // R1
  AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    !(($past(snkA) && snkB) || ($past(snkB) && snkA))); // R6
endmodule

bind chopBridgeCtl chopBridgeCtl_chk u_chk (
  .clk(clk), .rstN(rstN), .bridgeOffIn(bridgeOffIn), .tripIn(tripIn),
  .faultIn(faultIn), .srcA(srcA), .srcB(srcB), .snkA(snkA), .snkB(snkB)
);

// File: tb/test_chopBridgeCtl.sv
module test_chopBridgeCtl;
  localparam int CW = 8;
  localparam int OT = 10;
  localparam int BL = 4;
  localparam int DT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirIn = 1'b1, bridgeOffIn = 1'b0, tripIn = 1'b0, faultIn = 1'b0;
  logic srcA, srcB, snkA, snkB;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chopBridgeCtl #(.CW(CW)) i_chopBridgeCtl (
    .clk(clk), .rstN(rstN), .dirIn(dirIn), .bridgeOffIn(bridgeOffIn),
    .tripIn(tripIn), .faultIn(faultIn),
    .offTime(CW'(OT)), .blankTime(CW'(BL)), .deadTime(CW'(DT)),
    .srcA(srcA), .srcB(srcB), .snkA(snkA), .snkB(snkB)
  );

  // Behavioural reference: mode 0 off, 1 crossover gap, 2 driving, 3 recirculating
  int mMode = 0, mGap = 0, mBlank = 0;
  bit mDir = 0;
  bit dq[$] = '{0, 0};
  bit oq[$] = '{1, 1};

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mGap = 0; mBlank = 0; mDir = 0;
      dq = '{0, 0}; oq = '{1, 1};
    end else begin
      bit d, o, gapEnds, blanked;
      d = dq.pop_front(); o = oq.pop_front();
      dq.push_back(dirIn); oq.push_back(bridgeOffIn);
      gapEnds = (mGap == 1);
      blanked = (mBlank > 0);
      if (mGap > 0) mGap--;
      if (mBlank > 0) mBlank--;
      if (faultIn || o) mMode = 0;
      else if (mMode == 0) begin mMode = 2; mDir = d; mBlank = BL; end
      else if (mMode == 1) begin
        if (gapEnds) begin mMode = 2; mDir = d; mBlank = BL; end
      end else if (d != mDir) begin mMode = 1; mGap = DT; end
      else if (mMode == 2) begin
        if (!blanked && tripIn) begin mMode = 3; mGap = OT; end
      end else if (gapEnds) begin mMode = 2; mBlank = BL; end
    end
  end

  task automatic cyc(input string tag);
    logic [3:0] exp, act;
    @(negedge clk);
    exp = {(mMode == 2) && mDir, (mMode == 2) && !mDir,
           (mMode >= 2) && !mDir, (mMode >= 2) && mDir};
    act = {srcA, srcB, snkA, snkB};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t {srcA,srcB,snkA,snkB} actual=%b expected=%b", tag, $time, act, exp);
    end
    checks++;
    if ((srcA && snkA) || (srcB && snkB)) begin
      errors++;
      $display("FAIL R9 shoot-through actual=%b expected=no same-side pair", act);
    end
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10: outputs off during reset
    repeat (3) @(negedge clk);
    checks++;
    if ({srcA, srcB, snkA, snkB} !== 4'b0) begin
      errors++;
      $display("FAIL R10 reset actual=%b expected=0000", {srcA, srcB, snkA, snkB});
    end
    rstN = 1'b1;
    // R10/R5: trip held high from reset, chop cadence follows blanking and off-time
    tripIn = 1'b1;
    run("R10 R5 R4", 40);
    // R3/R4: single trip pulses
    tripIn = 1'b0; run("R3", 8);
    tripIn = 1'b1; cyc("R3"); tripIn = 1'b0;
    run("R4", 20);
    // R11: trips during off-time ignored
    tripIn = 1'b1; cyc("R3"); tripIn = 1'b0; run("R11", 3);
    tripIn = 1'b1; run("R11", 3); tripIn = 1'b0; run("R4", 12);
    // R2/R6: direction change while driving, trip high during gap
    dirIn = 1'b0; tripIn = 1'b1; run("R6 R11", 6);
    tripIn = 1'b0; run("R2 R6", 10);
    // R6: direction change during recirculation
    tripIn = 1'b1; cyc("R3"); tripIn = 1'b0; run("R4", 2);
    dirIn = 1'b1; run("R6", 12);
    // R6: short glitch of direction
    dirIn = 1'b0; cyc("R6"); dirIn = 1'b1; run("R6", 12);
    // R1/R11: bridge off, trips have no effect, direction irrelevant
    bridgeOffIn = 1'b1; tripIn = 1'b1; run("R1", 5);
    dirIn = 1'b0; run("R1 R11", 10);
    // R7: re-enable with trip high
    bridgeOffIn = 1'b0; run("R7", 25);
    // R8: fault in mid-chop, then resume with blanking
    faultIn = 1'b1; run("R8", 6);
    faultIn = 1'b0; run("R8 R7", 25);
    faultIn = 1'b1; cyc("R8"); faultIn = 1'b0; tripIn = 1'b0;
    run("R8 R2", 10);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule